// File: doc/BRIEF.md
# Scan-Line Window onto a Frame Buffer

This block lets a processor reach one horizontal line of a 640 x 480 frame buffer through a small, fixed address window. Software first writes a line number into a line-select register. Every later access to the window at offset X then goes to pixel (X, line) in the frame memory. The frame memory stores the pixels one line after another. Inside the window the processor can use a constant base address plus an index register. It never has to build a two-dimensional address itself.

The processor side is a plain single-cycle bus with address, write data, write enable and read data. The memory side presents an address, write data and a write enable, and takes read data back. The frame address is built combinationally from the stored line number and the window offset, so a window access takes effect in the same cycle it is presented. A new line number written in one cycle applies to any window access in the next cycle.

Top module: `line_window_top`

## Requirements
- R1: After a synchronous reset the line-select register holds 0. A read at control address 0x400 returns 0.
- R2: A write to control address 0x400 whose data is below 480 loads that value into the line-select register. A read at 0x400 returns the stored value, zero-extended, in the same cycle.
- R3: A write to 0x400 whose data is 480 or more is ignored, and the previous line number is kept.
- R4: A write at a window address (bit 10 clear) with offset X below 640 raises `fb_we` for that cycle. It drives `fb_addr` = line*640 + X and `fb_wdata` = `cpu_wdata`.
- R5: A read at a window address with offset X below 640 presents `fb_addr` = line*640 + X and returns `fb_rdata` on `cpu_rdata` in the same cycle.
- R6: A window address with offset 640 to 1023 never raises `fb_we`, and a read there returns 0.
- R7: A window access in the cycle right after a line-select write already uses the new line number.
- R8: A write to the control address or to any unmapped address (bit 10 set, other than 0x400) never raises `fb_we`. Reads at unmapped addresses return 0.
- R9: The last pixel (X=639, line 479) maps to frame address 307199.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 11 | Processor address: bit 10 clear selects the window, 0x400 selects the line register |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | 16 | Processor read data (combinational) |
| fb_addr | output | 19 | Frame memory address |
| fb_wdata | output | 16 | Frame memory write data |
| fb_we | output | 1 | Frame memory write enable |
| fb_rdata | input | 16 | Frame memory read data |

## Verification
Every memory-side output and the read data depend only on the current inputs and the stored line. The bench therefore checks them within the same cycle, a quarter period after it drives the inputs on the falling edge. A line-select write is due at the next rising edge. The reference model applies it only after that edge, so the first access that uses the new line is the one driven in the following cycle. The bench supplies memory read data as a fixed function of `fb_addr`, so a correct pass-through of the read data also confirms the address.

// File: rtl/line_window_pkg.sv
package line_window_pkg;

    // Frame geometry defaults
    localparam int unsigned DEF_LINE_PIXELS = 640;
    localparam int unsigned DEF_FRAME_LINES = 480;
    localparam int unsigned DEF_DATA_W      = 16;

    // Kind of processor access after decode
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WIN  = 2'd1,
        ACC_CTRL = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      x_ok;
    } decode_t;

    // True when a decoded access should reach the frame memory
    function automatic logic reaches_frame(decode_t d);
        return (d.kind == ACC_WIN) && d.x_ok;
    endfunction

endpackage

// File: rtl/line_sel_reg.sv
module line_sel_reg
    import line_window_pkg::*;
#(
    parameter int unsigned FRAME_LINES = DEF_FRAME_LINES,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    localparam int unsigned LINE_W     = $clog2(FRAME_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    output logic [LINE_W-1:0] line
);

    logic accept;

    always_comb begin
        accept = wr_en && (wr_val < DATA_W'(FRAME_LINES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (accept) begin
            line <= wr_val[LINE_W-1:0];
        end
    end

    // R3
    line_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        line < LINE_W'(FRAME_LINES));

    // R2
    line_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_val < DATA_W'(FRAME_LINES)) |=> (DATA_W'(line) == $past(wr_val)));

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_val >= DATA_W'(FRAME_LINES)) |=> $stable(line));

endmodule

// File: rtl/window_decode.sv
module window_decode
    import line_window_pkg::*;
#(
    parameter int unsigned LINE_PIXELS = DEF_LINE_PIXELS,
    localparam int unsigned X_W        = $clog2(LINE_PIXELS),
    localparam int unsigned A_W        = X_W + 1
) (
    input  logic [A_W-1:0] addr,
    output decode_t        dec,
    output logic [X_W-1:0] x
);

    localparam logic [A_W-1:0] CTRL_ADDR = {1'b1, {X_W{1'b0}}};

    always_comb begin
        x        = addr[X_W-1:0];
        dec.x_ok = (x < X_W'(LINE_PIXELS));
        if (!addr[X_W]) begin
            dec.kind = ACC_WIN;
        end else if (addr == CTRL_ADDR) begin
            dec.kind = ACC_CTRL;
        end else begin
            dec.kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen
    import line_window_pkg::*;
#(
    parameter int unsigned LINE_PIXELS = DEF_LINE_PIXELS,
    parameter int unsigned FRAME_LINES = DEF_FRAME_LINES,
    localparam int unsigned X_W        = $clog2(LINE_PIXELS),
    localparam int unsigned LINE_W     = $clog2(FRAME_LINES),
    localparam int unsigned FA_W       = $clog2(LINE_PIXELS * FRAME_LINES)
) (
    input  logic [LINE_W-1:0] line,
    input  logic [X_W-1:0]    x,
    output logic [FA_W-1:0]   fa
);

    generate
        if (LINE_PIXELS == 640) begin : g_shift
            // 640 = 512 + 128: two shifted copies of the line number
            always_comb begin
                fa = (FA_W'(line) << 9) + (FA_W'(line) << 7) + FA_W'(x);
            end
        end else begin : g_mult
            always_comb begin
                fa = FA_W'(line) * FA_W'(LINE_PIXELS) + FA_W'(x);
            end
        end
    endgenerate

endmodule

// File: rtl/line_window_top.sv
module line_window_top
    import line_window_pkg::*;
#(
    parameter int unsigned LINE_PIXELS = DEF_LINE_PIXELS,
    parameter int unsigned FRAME_LINES = DEF_FRAME_LINES,
    parameter int unsigned DATA_W      = DEF_DATA_W
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [$clog2(LINE_PIXELS):0]                   cpu_addr,
    input  logic [DATA_W-1:0]                              cpu_wdata,
    input  logic                                           cpu_we,
    output logic [DATA_W-1:0]                              cpu_rdata,
    output logic [$clog2(LINE_PIXELS*FRAME_LINES)-1:0]     fb_addr,
    output logic [DATA_W-1:0]                              fb_wdata,
    output logic                                           fb_we,
    input  logic [DATA_W-1:0]                              fb_rdata
);

    localparam int unsigned X_W    = $clog2(LINE_PIXELS);
    localparam int unsigned LINE_W = $clog2(FRAME_LINES);
    localparam int unsigned FA_W   = $clog2(LINE_PIXELS * FRAME_LINES);

    decode_t           dec;
    logic [X_W-1:0]    x;
    logic [LINE_W-1:0] line;
    logic              ctrl_wr;

    window_decode #(.LINE_PIXELS(LINE_PIXELS)) u_dec (
        .addr (cpu_addr),
        .dec  (dec),
        .x    (x)
    );

    always_comb begin
        ctrl_wr = cpu_we && (dec.kind == ACC_CTRL);
    end

    line_sel_reg #(.FRAME_LINES(FRAME_LINES), .DATA_W(DATA_W)) u_line (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wr_val (cpu_wdata),
        .line   (line)
    );

    frame_addr_gen #(.LINE_PIXELS(LINE_PIXELS), .FRAME_LINES(FRAME_LINES)) u_fa (
        .line (line),
        .x    (x),
        .fa   (fb_addr)
    );

    always_comb begin
        fb_wdata = cpu_wdata;
        fb_we    = cpu_we && reaches_frame(dec);
        if (reaches_frame(dec)) begin
            cpu_rdata = fb_rdata;
        end else if (dec.kind == ACC_CTRL) begin
            cpu_rdata = DATA_W'(line);
        end else begin
            cpu_rdata = '0;
        end
    end

    // R6
    no_far_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[X_W] && cpu_addr[X_W-1:0] >= X_W'(LINE_PIXELS)) |-> !fb_we);

    // R8
    no_ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[X_W] |-> !fb_we);

    // R4
    fb_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (fb_addr < FA_W'(LINE_PIXELS * FRAME_LINES)));

    // R6
    far_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[X_W] && cpu_addr[X_W-1:0] >= X_W'(LINE_PIXELS)) |-> (cpu_rdata == '0));

endmodule

// File: tb/line_window_top_test.sv
module line_window_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_rdata;
    logic [18:0] fb_addr;
    logic [15:0] fb_wdata;
    logic        fb_we;
    logic [15:0] fb_rdata;

    int checks = 0;
    int fails  = 0;
    int model_line = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory read data: a fixed pattern of the address
    always_comb fb_rdata = fb_addr[15:0] ^ 16'h5A3C;

    line_window_top uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .fb_addr(fb_addr),
        .fb_wdata(fb_wdata), .fb_we(fb_we), .fb_rdata(fb_rdata)
    );

    task automatic expect_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive on the falling edge, check, then let the edge pass
    task automatic step(string req, int addr, int wdata, bit we);
        int exp_fa;
        bit win, ok, ctrl;
        @(negedge clk);
        cpu_addr  = 11'(addr);
        cpu_wdata = 16'(wdata);
        cpu_we    = we;
        #(CLK_PERIOD/4);
        win    = (addr < 1024);
        ok     = win && (addr < 640);
        ctrl   = (addr == 1024);
        exp_fa = model_line * 640 + (addr % 1024);
        expect_eq(req, "fb_we", fb_we, we && ok);
        if (ok) begin
            expect_eq(req, "fb_addr", fb_addr, exp_fa);
            expect_eq(req, "rdata", cpu_rdata, (exp_fa & 16'hFFFF) ^ 16'h5A3C);
            if (we) expect_eq(req, "fb_wdata", fb_wdata, wdata);
        end else if (ctrl) begin
            expect_eq(req, "rdata", cpu_rdata, model_line);
        end else begin
            expect_eq(req, "rdata", cpu_rdata, 0);
        end
        @(posedge clk);
        if (ctrl && we && wdata < 480) model_line = wdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset value read back
        step("R1", 1024, 0, 1'b0);
        step("R4", 5, 16'h1234, 1'b1);
        step("R4", 0, 16'h00FF, 1'b1);
        // R2 and R7: new line used in the very next cycle
        step("R2", 1024, 20, 1'b1);
        step("R7", 20, 16'hBEEF, 1'b1);
        step("R2", 1024, 0, 1'b0);
        step("R5", 100, 0, 1'b0);
        // R3: out-of-range values are ignored
        step("R3", 1024, 480, 1'b1);
        step("R3", 1024, 0, 1'b0);
        step("R3", 1024, 16'hFFFF, 1'b1);
        step("R3", 7, 0, 1'b0);
        // R9: last line, last pixel
        step("R2", 1024, 479, 1'b1);
        step("R9", 639, 16'hCAFE, 1'b1);
        step("R9", 639, 0, 1'b0);
        // R6: offsets beyond the line
        step("R6", 640, 16'h7777, 1'b1);
        step("R6", 1023, 0, 1'b0);
        step("R6", 800, 0, 1'b0);
        // R8: control and unmapped addresses never write memory
        step("R8", 1025, 16'h0011, 1'b1);
        step("R8", 2047, 0, 1'b0);
        step("R8", 1024, 3, 1'b1);
        step("R7", 639, 16'h0101, 1'b1);
        step("R2", 1024, 0, 1'b0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule